// File: doc/BRIEF.md
# Off-Chip Data Memory Access Sequencer

This block sits between a small CPU core and a byte-wide off-chip data memory. When the CPU asks for a read or a write, the block drives a 24-bit address, strobes the memory for a programmable number of clocks and returns either the read byte or a completion pulse. The strobe width comes from a stretch setting, so one design can serve both fast and slow memories. A separate enable tells the board-level tri-state buffers when the block is driving the data bus.

Addresses come from one of two sources. The first is a bank of two 24-bit data pointers, each made of low, high and page bytes. One of them is active at a time. After an access, the active pointer can be stepped up or down, and an optional auto-switch then hands over to the other pointer, which makes block copies cheap. The second source is a register-indirect form that joins a 16-bit extension register with an 8-bit low address supplied with the request.

Top module: `xmem_seq`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears mem_rd, mem_wr, mem_drive, busy and done. It also sets both pointers to 0, the active pointer to 0 and the stretch setting to 0.
- R2: A request (req_valid high while busy is low) is accepted at a clock edge. From the next cycle, mem_addr holds the access address and stays stable while busy is high. mem_rd (read, req_write=0) or mem_wr (write, req_write=1) is high for the stretched strobe width. The two strobes are never high together.
- R3: A read captures mem_din on the last strobe clock. In the cycle right after the strobe, done is high for exactly one cycle and rdata holds the captured byte.
- R4: A write drives req_wdata on mem_dout for the whole strobe. One hold cycle follows with mem_wr low and mem_addr and mem_dout unchanged. done pulses for one cycle in the cycle after the hold cycle.
- R5: mem_drive (1 = block drives the data bus) is high from the first write strobe cycle through the hold cycle and is never high during a read.
- R6: A stretch value v (0 to 7, written through cfg_stretch_we) gives a strobe of v+1 clocks. The value is taken when a request is accepted, so a change while busy affects only later accesses.
- R7: A pointer access (req_indirect=0) uses the active pointer's full 24 bits as the address, with the page byte as bits 23:16.
- R8: A pointer access with req_step=1 steps the active pointer after the address is taken. The step is +1 when cfg_dec bit i is 0 and -1 when it is 1 (i = pointer index). Arithmetic is modulo 2^24, so a carry or borrow passes into the page byte.
- R9: When cfg_autosw=1, every stepped pointer access also advances the active pointer to the other one (ptr_active toggles). Accesses without a step never switch.
- R10: An indirect access (req_indirect=1) uses address {extension register, req_lo} and leaves both pointers and the active pointer unchanged, even with req_step=1.
- R11: busy is high from the cycle after acceptance until the done cycle, and low in the done cycle. A request presented while busy is dropped: it produces no strobe and changes no pointer.
- R12: ptr_we loads pointer ptr_id with ptr_val. ptr_sel_we makes ptr_sel_val the active pointer, which is shown on ptr_active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cfg_stretch_we | input | 1 | Write strobe for the stretch setting |
| cfg_stretch_val | input | 3 | Stretch value v, strobe is v+1 clocks |
| cfg_ext_we | input | 1 | Write strobe for the extension register |
| cfg_ext_val | input | 16 | Upper address bits for indirect accesses |
| cfg_dec | input | 2 | Per-pointer step direction, 1 = decrement |
| cfg_autosw | input | 1 | Enable pointer switch after each stepped access |
| ptr_we | input | 1 | Load a pointer |
| ptr_id | input | 1 | Index of the pointer to load |
| ptr_val | input | 24 | Value to load |
| ptr_sel_we | input | 1 | Set the active pointer |
| ptr_sel_val | input | 1 | New active pointer index |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_indirect | input | 1 | 1 = indirect address, 0 = active pointer |
| req_step | input | 1 | Step the active pointer after the access |
| req_lo | input | 8 | Low address byte for indirect accesses |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | Access in progress, new requests dropped |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Captured read data |
| ptr_active | output | 1 | Index of the active pointer |
| mem_addr | output | 24 | Memory address |
| mem_dout | output | 8 | Data to memory |
| mem_din | input | 8 | Data from memory |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_drive | output | 1 | Data bus buffer enable, 1 = drive |

## Verification
With a stretch value v, each accepted request shows its strobe in cycles 1 through v+1 after the accepting edge. A read then raises done and presents rdata in cycle v+2. A write keeps drive, address and data in cycle v+2 and raises done in cycle v+3. The bench accepts each request at one edge and checks the outputs at every following falling edge against this schedule, so every strobe cycle, the hold cycle and the done cycle are each checked in the exact cycle they are due. Pointer steps, switches and dropped requests are checked one access later, through the address of the next access and ptr_active.

// File: rtl/xmem_pkg.sv
`timescale 1ns/1ps
package xmem_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_STRB = 2'd1,
      ST_HOLD = 2'd2
   } seq_state_e;
endpackage

// File: rtl/xmem_strobe_timer.sv
`timescale 1ns/1ps
module xmem_strobe_timer #(
   parameter int SW = 3
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          start,
   input  logic [SW-1:0] len_m1,
   output logic          active,
   output logic          last
);
   logic [SW-1:0] cnt_q;
   logic          act_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         act_q <= 1'b0;
         cnt_q <= '0;
      end else if (start) begin
         act_q <= 1'b1;
         cnt_q <= len_m1;
      end else if (act_q) begin
         if (cnt_q == '0) act_q <= 1'b0;
         else             cnt_q <= cnt_q - SW'(1);
      end
   end

   assign active = act_q;
   assign last   = act_q && (cnt_q == '0);

   // width checker: counts strobe cycles and compares on the falling edge
   logic [SW:0]   chk_w;
   logic [SW-1:0] chk_len;
   always_ff @(posedge clk) begin
      if (rst) begin
         chk_w   <= '0;
         chk_len <= '0;
      end else if (start) begin
         chk_w   <= (SW+1)'(1);
         chk_len <= len_m1;
      end else if (act_q && !last) begin
         chk_w <= chk_w + (SW+1)'(1);
      end
   end

   assert_strobe_width_R6: assert property (@(posedge clk) disable iff (rst)
      $fell(act_q) |-> (chk_w == ({1'b0, chk_len} + (SW+1)'(1))));

   assert_no_restart_R11: assert property (@(posedge clk) disable iff (rst)
      start |-> !act_q);
endmodule

// File: rtl/xmem_ptr_bank.sv
`timescale 1ns/1ps
module xmem_ptr_bank #(
   parameter  int AW        = 24,
   parameter  int NPTR      = 2,
   parameter  bit AUTOSW_EN = 1'b1,
   localparam int PSEL_W    = (NPTR > 1) ? $clog2(NPTR) : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ld_we,
   input  logic [PSEL_W-1:0] ld_id,
   input  logic [AW-1:0]     ld_val,
   input  logic              sel_we,
   input  logic [PSEL_W-1:0] sel_val,
   input  logic              step_en,
   input  logic [NPTR-1:0]   cfg_dec,
   input  logic              cfg_autosw,
   output logic [AW-1:0]     cur_ptr,
   output logic [PSEL_W-1:0] act_id
);
   initial begin
      chk_nptr_ok: assert (NPTR >= 2) else $fatal(1, "xmem_ptr_bank needs two or more pointers");
   end

   logic [AW-1:0]     ptr_q [NPTR];
   logic [PSEL_W-1:0] act_q;
   logic [PSEL_W-1:0] act_nxt;
   logic              sw_now;

   assign act_nxt = (act_q == PSEL_W'(NPTR-1)) ? '0 : act_q + PSEL_W'(1);

   generate
      if (AUTOSW_EN) begin : g_autosw
         assign sw_now = step_en && cfg_autosw;
      end else begin : g_fixed
         assign sw_now = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < NPTR; i++) ptr_q[i] <= '0;
         act_q <= '0;
      end else begin
         for (int i = 0; i < NPTR; i++) begin
            if (ld_we && ld_id == PSEL_W'(i))
               ptr_q[i] <= ld_val;
            else if (step_en && act_q == PSEL_W'(i))
               ptr_q[i] <= cfg_dec[i] ? ptr_q[i] - AW'(1) : ptr_q[i] + AW'(1);
         end
         if (sel_we)      act_q <= sel_val;
         else if (sw_now) act_q <= act_nxt;
      end
   end

   assign cur_ptr = ptr_q[act_q];
   assign act_id  = act_q;

   assert_switch_moves_R9: assert property (@(posedge clk) disable iff (rst)
      (sw_now && !sel_we) |=> (act_q != $past(act_q)));

   assert_hold_sel_R12: assert property (@(posedge clk) disable iff (rst)
      (!sel_we && !sw_now) |=> $stable(act_q));
endmodule

// File: rtl/xmem_seq.sv
`timescale 1ns/1ps
module xmem_seq
   import xmem_pkg::*;
#(
   parameter  int AW        = 24,
   parameter  int DW        = 8,
   parameter  int SW        = 3,
   parameter  int NPTR      = 2,
   parameter  int LOW_W     = 8,
   parameter  bit AUTOSW_EN = 1'b1,
   localparam int EXT_W     = AW - LOW_W,
   localparam int PSEL_W    = (NPTR > 1) ? $clog2(NPTR) : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cfg_stretch_we,
   input  logic [SW-1:0]     cfg_stretch_val,
   input  logic              cfg_ext_we,
   input  logic [EXT_W-1:0]  cfg_ext_val,
   input  logic [NPTR-1:0]   cfg_dec,
   input  logic              cfg_autosw,
   input  logic              ptr_we,
   input  logic [PSEL_W-1:0] ptr_id,
   input  logic [AW-1:0]     ptr_val,
   input  logic              ptr_sel_we,
   input  logic [PSEL_W-1:0] ptr_sel_val,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic              req_indirect,
   input  logic              req_step,
   input  logic [LOW_W-1:0]  req_lo,
   input  logic [DW-1:0]     req_wdata,
   output logic              busy,
   output logic              done,
   output logic [DW-1:0]     rdata,
   output logic [PSEL_W-1:0] ptr_active,
   output logic [AW-1:0]     mem_addr,
   output logic [DW-1:0]     mem_dout,
   input  logic [DW-1:0]     mem_din,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic              mem_drive
);
   initial begin
      chk_aw_ok: assert (AW > LOW_W) else $fatal(1, "address must be wider than the indirect low part");
      chk_sw_ok: assert (SW >= 1)    else $fatal(1, "stretch field needs at least one bit");
   end

   seq_state_e      state_q;
   logic            is_wr_q;
   logic [AW-1:0]   addr_q;
   logic [DW-1:0]   wdata_q;
   logic [DW-1:0]   rdata_q;
   logic            done_q;
   logic [SW-1:0]   stretch_q;
   logic [EXT_W-1:0] ext_q;

   logic            accept;
   logic            step_en;
   logic [AW-1:0]   ptr_addr;
   logic [AW-1:0]   acc_addr;
   logic            tmr_active;
   logic            tmr_last;

   assign accept   = req_valid && (state_q == ST_IDLE);
   assign step_en  = accept && !req_indirect && req_step;
   assign acc_addr = req_indirect ? {ext_q, req_lo} : ptr_addr;

   xmem_ptr_bank #(
      .AW(AW), .NPTR(NPTR), .AUTOSW_EN(AUTOSW_EN)
   ) i_ptr_bank (
      .clk(clk), .rst(rst),
      .ld_we(ptr_we), .ld_id(ptr_id), .ld_val(ptr_val),
      .sel_we(ptr_sel_we), .sel_val(ptr_sel_val),
      .step_en(step_en), .cfg_dec(cfg_dec), .cfg_autosw(cfg_autosw),
      .cur_ptr(ptr_addr), .act_id(ptr_active)
   );

   xmem_strobe_timer #(.SW(SW)) i_strobe_timer (
      .clk(clk), .rst(rst),
      .start(accept), .len_m1(stretch_q),
      .active(tmr_active), .last(tmr_last)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q   <= ST_IDLE;
         is_wr_q   <= 1'b0;
         addr_q    <= '0;
         wdata_q   <= '0;
         rdata_q   <= '0;
         done_q    <= 1'b0;
         stretch_q <= '0;
         ext_q     <= '0;
      end else begin
         done_q <= 1'b0;
         if (cfg_stretch_we) stretch_q <= cfg_stretch_val;
         if (cfg_ext_we)     ext_q     <= cfg_ext_val;
         case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  state_q <= ST_STRB;
                  is_wr_q <= req_write;
                  addr_q  <= acc_addr;
                  wdata_q <= req_wdata;
               end
            end
            ST_STRB: begin
               if (tmr_last) begin
                  if (is_wr_q) begin
                     state_q <= ST_HOLD;
                  end else begin
                     state_q <= ST_IDLE;
                     done_q  <= 1'b1;
                     rdata_q <= mem_din;
                  end
               end
            end
            ST_HOLD: begin
               state_q <= ST_IDLE;
               done_q  <= 1'b1;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy      = (state_q != ST_IDLE);
   assign done      = done_q;
   assign rdata     = rdata_q;
   assign mem_addr  = addr_q;
   assign mem_dout  = wdata_q;
   assign mem_rd    = tmr_active && !is_wr_q;
   assign mem_wr    = tmr_active && is_wr_q;
   assign mem_drive = is_wr_q && (state_q != ST_IDLE);

   assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (rst)
      !(mem_rd && mem_wr));

   assert_addr_stable_R2: assert property (@(posedge clk) disable iff (rst)
      (busy && $past(busy)) |-> $stable(mem_addr));

   assert_done_pulse_R3: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   assert_hold_stable_R4: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_HOLD) |-> (!mem_wr && $stable(mem_addr) && $stable(mem_dout)));

   assert_drive_write_only_R5: assert property (@(posedge clk) disable iff (rst)
      mem_drive |-> !mem_rd);

   assert_strobe_in_busy_R11: assert property (@(posedge clk) disable iff (rst)
      (mem_rd || mem_wr) |-> busy);

   assert_done_not_busy_R11: assert property (@(posedge clk) disable iff (rst)
      done |-> !busy);
endmodule

// File: tb/test_xmem_seq.sv
`timescale 1ns/1ps
module test_xmem_seq;
   logic        clk = 1'b0;
   logic        rst;
   logic        cfg_stretch_we;
   logic [2:0]  cfg_stretch_val;
   logic        cfg_ext_we;
   logic [15:0] cfg_ext_val;
   logic [1:0]  cfg_dec;
   logic        cfg_autosw;
   logic        ptr_we;
   logic [0:0]  ptr_id;
   logic [23:0] ptr_val;
   logic        ptr_sel_we;
   logic [0:0]  ptr_sel_val;
   logic        req_valid, req_write, req_indirect, req_step;
   logic [7:0]  req_lo, req_wdata;
   logic        busy, done;
   logic [7:0]  rdata;
   logic [0:0]  ptr_active;
   logic [23:0] mem_addr;
   logic [7:0]  mem_dout, mem_din;
   logic        mem_rd, mem_wr, mem_drive;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   function automatic logic [7:0] mdat(input logic [23:0] a);
      return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
   endfunction

   assign mem_din = mdat(mem_addr);

   xmem_seq i_xmem_seq (
      .clk(clk), .rst(rst),
      .cfg_stretch_we(cfg_stretch_we), .cfg_stretch_val(cfg_stretch_val),
      .cfg_ext_we(cfg_ext_we), .cfg_ext_val(cfg_ext_val),
      .cfg_dec(cfg_dec), .cfg_autosw(cfg_autosw),
      .ptr_we(ptr_we), .ptr_id(ptr_id), .ptr_val(ptr_val),
      .ptr_sel_we(ptr_sel_we), .ptr_sel_val(ptr_sel_val),
      .req_valid(req_valid), .req_write(req_write), .req_indirect(req_indirect),
      .req_step(req_step), .req_lo(req_lo), .req_wdata(req_wdata),
      .busy(busy), .done(done), .rdata(rdata), .ptr_active(ptr_active),
      .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_din(mem_din),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_drive(mem_drive)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic set_stretch(input logic [2:0] v);
      @(negedge clk); cfg_stretch_we = 1'b1; cfg_stretch_val = v;
      @(negedge clk); cfg_stretch_we = 1'b0;
   endtask

   task automatic load_ptr(input logic id, input logic [23:0] v);
      @(negedge clk); ptr_we = 1'b1; ptr_id = id; ptr_val = v;
      @(negedge clk); ptr_we = 1'b0;
   endtask

   task automatic sel_ptr(input logic id);
      @(negedge clk); ptr_sel_we = 1'b1; ptr_sel_val = id;
      @(negedge clk); ptr_sel_we = 1'b0;
      chk("R12", "ptr_active after select", 32'(ptr_active), 32'(id));
   endtask

   task automatic set_ext(input logic [15:0] v);
      @(negedge clk); cfg_ext_we = 1'b1; cfg_ext_val = v;
      @(negedge clk); cfg_ext_we = 1'b0;
   endtask

   // one access, checked cycle by cycle; n = expected strobe length
   task automatic run_access(input bit wr, input bit ind, input bit step,
                             input logic [7:0] lo, input logic [7:0] wd,
                             input logic [23:0] ea, input int n, input string req);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_indirect = ind; req_step = step;
      req_lo = lo; req_wdata = wd;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      for (int k = 1; k <= n; k++) begin
         chk(req, "strobe rd", 32'(mem_rd), 32'(!wr));
         chk(req, "strobe wr", 32'(mem_wr), 32'(wr));
         chk(req, "address", 32'(mem_addr), 32'(ea));
         chk("R5", "drive in strobe", 32'(mem_drive), 32'(wr));
         chk("R11", "busy in strobe", 32'(busy), 32'd1);
         chk(req, "no early done", 32'(done), 32'd0);
         if (wr) chk("R4", "write data", 32'(mem_dout), 32'(wd));
         if (k < n) @(negedge clk);
      end
      @(negedge clk);
      if (wr) begin
         chk("R4", "hold wr low", 32'(mem_wr), 32'd0);
         chk("R4", "hold address", 32'(mem_addr), 32'(ea));
         chk("R4", "hold data", 32'(mem_dout), 32'(wd));
         chk("R5", "hold drive", 32'(mem_drive), 32'd1);
         chk("R4", "hold no done", 32'(done), 32'd0);
         chk("R11", "hold busy", 32'(busy), 32'd1);
         @(negedge clk);
      end else begin
         chk("R3", "rdata", 32'(rdata), 32'(mdat(ea)));
      end
      chk(wr ? "R4" : "R3", "done pulse", 32'(done), 32'd1);
      chk("R11", "busy low at done", 32'(busy), 32'd0);
      chk("R5", "drive off at done", 32'(mem_drive), 32'd0);
      chk(req, "strobes off at done", 32'({mem_rd, mem_wr}), 32'd0);
   endtask

   task automatic t_reset;
      chk("R1", "rd", 32'(mem_rd), 32'd0);
      chk("R1", "wr", 32'(mem_wr), 32'd0);
      chk("R1", "drive", 32'(mem_drive), 32'd0);
      chk("R1", "busy", 32'(busy), 32'd0);
      chk("R1", "done", 32'(done), 32'd0);
      chk("R1", "active ptr", 32'(ptr_active), 32'd0);
      // pointer 0 at zero, stretch 0 gives a single-clock strobe
      run_access(1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 24'h000000, 1, "R1");
   endtask

   task automatic t_carry;
      load_ptr(1'b0, 24'h12FFFF);
      load_ptr(1'b1, 24'h340000);
      set_stretch(3'd3);
      run_access(1'b0, 1'b0, 1'b1, 8'h00, 8'h00, 24'h12FFFF, 4, "R7");
      run_access(1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 24'h130000, 4, "R8");
   endtask

   task automatic t_borrow;
      cfg_dec = 2'b10;
      sel_ptr(1'b1);
      run_access(1'b0, 1'b0, 1'b1, 8'h00, 8'h00, 24'h340000, 4, "R7");
      run_access(1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 24'h33FFFF, 4, "R8");
   endtask

   task automatic t_long_write;
      set_stretch(3'd7);
      run_access(1'b1, 1'b0, 1'b0, 8'h00, 8'hC3, 24'h33FFFF, 8, "R6");
   endtask

   task automatic t_autoswitch;
      cfg_autosw = 1'b1;
      sel_ptr(1'b0);
      set_stretch(3'd1);
      run_access(1'b0, 1'b0, 1'b1, 8'h00, 8'h00, 24'h130000, 2, "R9");
      chk("R9", "switched to ptr1", 32'(ptr_active), 32'd1);
      run_access(1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 24'h33FFFF, 2, "R9");
      run_access(1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 24'h33FFFF, 2, "R9");
      chk("R9", "no switch without step", 32'(ptr_active), 32'd1);
      run_access(1'b1, 1'b0, 1'b1, 8'h00, 8'h5E, 24'h33FFFF, 2, "R9");
      chk("R9", "switched back to ptr0", 32'(ptr_active), 32'd0);
      run_access(1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 24'h130001, 2, "R8");
      cfg_autosw = 1'b0;
   endtask

   task automatic t_indirect;
      set_ext(16'hABCD);
      run_access(1'b0, 1'b1, 1'b0, 8'h42, 8'h00, 24'hABCD42, 2, "R10");
      run_access(1'b1, 1'b1, 1'b1, 8'h07, 8'h99, 24'hABCD07, 2, "R10");
      chk("R10", "active ptr unchanged", 32'(ptr_active), 32'd0);
      run_access(1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 24'h130001, 2, "R10");
   endtask

   task automatic t_busy;
      int wr_seen = 0;
      set_stretch(3'd2);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_indirect = 1'b0; req_step = 1'b0;
      @(posedge clk);
      @(negedge clk);                        // strobe cycle 1
      req_valid = 1'b0;
      chk("R11", "busy after accept", 32'(busy), 32'd1);
      @(negedge clk);                        // strobe cycle 2: late request
      req_valid = 1'b1; req_write = 1'b1; req_step = 1'b1; req_wdata = 8'hEE;
      cfg_stretch_we = 1'b1; cfg_stretch_val = 3'd0;
      @(negedge clk);                        // strobe cycle 3
      req_valid = 1'b0; req_step = 1'b0; cfg_stretch_we = 1'b0;
      chk("R6", "old width kept", 32'(mem_rd), 32'd1);
      if (mem_wr) wr_seen++;
      @(negedge clk);                        // done cycle
      chk("R11", "done after 3", 32'(done), 32'd1);
      chk("R3", "rdata busy read", 32'(rdata), 32'(mdat(24'h130001)));
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         if (mem_wr || mem_rd) wr_seen++;
         chk("R11", "dropped request idle", 32'(busy), 32'd0);
      end
      chk("R11", "no strobe from dropped request", 32'(wr_seen), 32'd0);
      run_access(1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 24'h130001, 1, "R11");
   endtask

   initial begin
      rst = 1'b1;
      cfg_stretch_we = 1'b0; cfg_stretch_val = '0;
      cfg_ext_we = 1'b0; cfg_ext_val = '0;
      cfg_dec = 2'b00; cfg_autosw = 1'b0;
      ptr_we = 1'b0; ptr_id = '0; ptr_val = '0;
      ptr_sel_we = 1'b0; ptr_sel_val = '0;
      req_valid = 1'b0; req_write = 1'b0; req_indirect = 1'b0; req_step = 1'b0;
      req_lo = '0; req_wdata = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_carry();
      t_borrow();
      t_long_write();
      t_autoswitch();
      t_indirect();
      t_busy();
      repeat (2) @(negedge clk);
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule